// File: doc/BRIEF.md
# UART Automatic Flow Control Engine

This block sits between a UART's receive FIFO, its transmit FIFO and its serial shifters and runs both kinds of automatic flow control without software help. On the hardware side it watches the receive FIFO fill level against a high and a low watermark and drives the active-low request-to-send output. It also watches the active-low clear-to-send input and holds the transmitter off at a character boundary.

On the software side it compares every received character against four programmable characters: two resume codes and two stop codes. A match stops or resumes the transmitter, and matched codes are kept out of the receive FIFO. In the wide (two-character) mode, a first code byte is held back until the next byte shows whether the pair is complete. The engine also asks the transmitter to insert a stop or resume code when the local FIFO crosses its watermarks, and it raises single-cycle event pulses for each flow-control event.

The transmitter reports its boundaries with an idle level and a character-done strobe. The engine changes its halt output only at those points.

Top module: `uart_flow_engine`

## Requirements
- R1: After reset, txHalt, every event pulse, xonReq, xoffReq and rxPush are 0, and rtsN equals the inverse of mcrRts.
- R2: With autoRtsEn=1 and mcrRts=1, rtsN goes to 1 on the first clock edge at which rxLevel is strictly greater than haltLevel. It stays 0 while rxLevel equals haltLevel.
- R3: Once rtsN has been raised by R2, it stays 1 while resumeLevel <= rxLevel. It returns to 0 on the first clock edge at which rxLevel < resumeLevel.
- R4: rtsIrq is a one-cycle pulse in the same cycle that R2 raises rtsN.
- R5: With autoCtsEn=1 and ctsN=1, txHalt rises only at a clock edge where txIdle or txCharDone is 1. After ctsN returns to 0, txHalt falls only at such an edge.
- R6: ctsIrq pulses for one cycle, one edge after ctsN rises, when autoCtsEn=1. It stays 0 when autoCtsEn=0.
- R7: In narrow mode (swFlowEn=1, swWide=0), a received xoff1 sets the stop state and a received xon1 clears it. Neither code is pushed. xoffIrq or xonIrq pulses one edge after the code, and txHalt follows at the next boundary.
- R8: In wide mode (swWide=1), xoff1 followed directly by xoff2 stops the transmitter, and xon1 followed directly by xon2 resumes it. Neither byte of a matched pair is pushed.
- R9: In wide mode, a held first code byte that is followed by a non-matching byte is pushed in the same cycle as that byte arrives. The non-matching byte is pushed one cycle later, so the order is kept and the stop state is unchanged.
- R10: A received character that is not consumed as a flow code gives rxPush=1 with rxPushData equal to it in the same cycle as rxValid. With swFlowEn=0, every character is forwarded this way.
- R11: With swFlowEn=1, xoffReq pulses for one cycle when the high-watermark state of R2 sets, and xonReq pulses for one cycle when it clears.
- R12: With autoCtsEn=0 and swFlowEn=0, txHalt stays 0 whatever ctsN and the received characters are. With autoRtsEn=0, rtsN follows the inverse of mcrRts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| autoRtsEn | input | 1 | Enable watermark-driven rtsN |
| autoCtsEn | input | 1 | Enable ctsN-driven transmit halt |
| swFlowEn | input | 1 | Enable code matching and code insert requests |
| swWide | input | 1 | 1: codes are two-byte pairs, 0: single bytes |
| mcrRts | input | 1 | Software request-to-send level (1 = assert) |
| rxLevel | input | LEVEL_W | Receive FIFO fill count |
| haltLevel | input | LEVEL_W | High watermark |
| resumeLevel | input | LEVEL_W | Low watermark |
| rxChar | input | CHAR_W | Received character |
| rxValid | input | 1 | rxChar strobe |
| xon1 | input | CHAR_W | First resume code |
| xon2 | input | CHAR_W | Second resume code |
| xoff1 | input | CHAR_W | First stop code |
| xoff2 | input | CHAR_W | Second stop code |
| ctsN | input | 1 | Clear-to-send, active low |
| txIdle | input | 1 | Transmitter not shifting |
| txCharDone | input | 1 | Transmitter finished a character this cycle |
| rtsN | output | 1 | Request-to-send, active low |
| txHalt | output | 1 | Hold off the transmitter |
| rxPush | output | 1 | Write strobe toward the receive FIFO |
| rxPushData | output | CHAR_W | Character to write |
| xoffReq | output | 1 | Ask transmitter to insert a stop code |
| xonReq | output | 1 | Ask transmitter to insert a resume code |
| rtsIrq | output | 1 | Event: rtsN raised by watermark |
| ctsIrq | output | 1 | Event: ctsN rose |
| xoffIrq | output | 1 | Event: stop code matched |
| xonIrq | output | 1 | Event: resume code matched |

## Verification
The bench uses the defaults LEVEL_W=5 and CHAR_W=8. A five-bit level covers a 16-entry FIFO count, which lets the bench place the fill level exactly on, one above and one below each watermark, so the strict-compare and hysteresis edges are all reached. Eight-bit characters allow four distinct codes, so the bench can break a two-byte pair with a plain data byte and follow the held byte and the new byte into the FIFO in order.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int HIT_XON1  = 0;
  localparam int HIT_XON2  = 1;
  localparam int HIT_XOFF1 = 2;
  localparam int HIT_XOFF2 = 3;
  localparam int NUM_CODES = 4;

  typedef struct packed {
    logic pushLive;
    logic pushHeld;
    logic loadHeld;
    logic setStop;
    logic clrStop;
  } flowStrobe_t;

  typedef enum logic [1:0] {
    MT_IDLE,
    MT_HOLD_ON,
    MT_HOLD_OFF,
    MT_FLUSH
  } matchState_t;
endpackage

// File: rtl/flowctl_match_ctrl.sv
module flowctl_match_ctrl
  import flowctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 swFlowEn,
  input  logic                 swWide,
  input  logic                 rxValid,
  input  logic [NUM_CODES-1:0] hit,
  output flowStrobe_t          st
);
  matchState_t state, nxt;
  logic wideOn;

  assign wideOn = swFlowEn && swWide;

  always_comb begin
    st  = '0;
    nxt = state;
    unique case (state)
      MT_IDLE: begin
        if (rxValid) begin
          if (!swFlowEn) begin
            st.pushLive = 1'b1;
          end else if (!swWide) begin
            if (hit[HIT_XOFF1])     st.setStop  = 1'b1;
            else if (hit[HIT_XON1]) st.clrStop  = 1'b1;
            else                    st.pushLive = 1'b1;
          end else if (hit[HIT_XOFF1]) begin
            st.loadHeld = 1'b1;
            nxt = MT_HOLD_OFF;
          end else if (hit[HIT_XON1]) begin
            st.loadHeld = 1'b1;
            nxt = MT_HOLD_ON;
          end else begin
            st.pushLive = 1'b1;
          end
        end
      end
      MT_HOLD_ON, MT_HOLD_OFF: begin
        if (rxValid) begin
          if (wideOn && state == MT_HOLD_OFF && hit[HIT_XOFF2]) begin
            st.setStop = 1'b1;
            nxt = MT_IDLE;
          end else if (wideOn && state == MT_HOLD_ON && hit[HIT_XON2]) begin
            st.clrStop = 1'b1;
            nxt = MT_IDLE;
          end else begin
            // release the held byte now, keep the new one for the next cycle
            st.pushHeld = 1'b1;
            st.loadHeld = 1'b1;
            if (wideOn && hit[HIT_XOFF1])     nxt = MT_HOLD_OFF;
            else if (wideOn && hit[HIT_XON1]) nxt = MT_HOLD_ON;
            else                              nxt = MT_FLUSH;
          end
        end else if (!wideOn) begin
          st.pushHeld = 1'b1;
          nxt = MT_IDLE;
        end
      end
      MT_FLUSH: begin
        st.pushHeld = 1'b1;
        nxt = MT_IDLE;
      end
      default: nxt = MT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MT_IDLE;
    else       state <= nxt;
  end

  // R9: a broken pair never leaves two bytes waiting
  p_flush_drains_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == MT_FLUSH) |=> (state != MT_FLUSH));
endmodule

// File: rtl/flowctl_datapath.sv
module flowctl_datapath
  import flowctl_pkg::*;
#(
  parameter int LEVEL_W = 5,
  parameter int CHAR_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 autoRtsEn,
  input  logic                 autoCtsEn,
  input  logic                 swFlowEn,
  input  logic                 mcrRts,
  input  logic [LEVEL_W-1:0]   rxLevel,
  input  logic [LEVEL_W-1:0]   haltLevel,
  input  logic [LEVEL_W-1:0]   resumeLevel,
  input  logic [CHAR_W-1:0]    rxChar,
  input  logic [CHAR_W-1:0]    xon1,
  input  logic [CHAR_W-1:0]    xon2,
  input  logic [CHAR_W-1:0]    xoff1,
  input  logic [CHAR_W-1:0]    xoff2,
  input  logic                 ctsN,
  input  logic                 txIdle,
  input  logic                 txCharDone,
  input  flowStrobe_t          st,
  output logic [NUM_CODES-1:0] hit,
  output logic                 rtsN,
  output logic                 txHalt,
  output logic                 rxPush,
  output logic [CHAR_W-1:0]    rxPushData,
  output logic                 xoffReq,
  output logic                 xonReq,
  output logic                 rtsIrq,
  output logic                 ctsIrq,
  output logic                 xoffIrq,
  output logic                 xonIrq
);
  logic [CHAR_W-1:0] codeTab [NUM_CODES];
  logic [CHAR_W-1:0] holdReg;
  logic rxFull, fullNext, swStopped, ctsPrev, haltReq, boundary, anyAuto;

  assign codeTab[HIT_XON1]  = xon1;
  assign codeTab[HIT_XON2]  = xon2;
  assign codeTab[HIT_XOFF1] = xoff1;
  assign codeTab[HIT_XOFF2] = xoff2;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
    assign hit[g] = (rxChar == codeTab[g]);
  end

  always_comb begin
    if (rxLevel > haltLevel)        fullNext = 1'b1;
    else if (rxLevel < resumeLevel) fullNext = 1'b0;
    else                            fullNext = rxFull;
  end

  assign rtsN       = !mcrRts || (autoRtsEn && rxFull);
  assign haltReq    = (autoCtsEn && ctsN) || swStopped;
  assign boundary   = txIdle || txCharDone;
  assign anyAuto    = autoCtsEn || swFlowEn;
  assign rxPush     = st.pushLive || st.pushHeld;
  assign rxPushData = st.pushHeld ? holdReg : rxChar;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull    <= 1'b0;
      swStopped <= 1'b0;
      txHalt    <= 1'b0;
      holdReg   <= '0;
      ctsPrev   <= 1'b1;
      rtsIrq    <= 1'b0;
      ctsIrq    <= 1'b0;
      xoffIrq   <= 1'b0;
      xonIrq    <= 1'b0;
      xoffReq   <= 1'b0;
      xonReq    <= 1'b0;
    end else begin
      rxFull  <= fullNext;
      rtsIrq  <= autoRtsEn && mcrRts && fullNext && !rxFull;
      xoffReq <= swFlowEn && fullNext && !rxFull;
      xonReq  <= swFlowEn && !fullNext && rxFull;
      ctsPrev <= ctsN;
      ctsIrq  <= autoCtsEn && ctsN && !ctsPrev;
      xoffIrq <= st.setStop;
      xonIrq  <= st.clrStop;
      if (st.loadHeld) holdReg <= rxChar;
      if (!swFlowEn)        swStopped <= 1'b0;
      else if (st.setStop)  swStopped <= 1'b1;
      else if (st.clrStop)  swStopped <= 1'b0;
      if (!anyAuto)      txHalt <= 1'b0;
      else if (boundary) txHalt <= haltReq;
    end
  end

  p_full_on_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(rxLevel > haltLevel));
  p_hyst_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(rxLevel < resumeLevel));
  p_rts_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rtsIrq |=> !rtsIrq);
  p_halt_rise_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txHalt) |-> $past(txIdle || txCharDone));
  p_single_push_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.pushLive, st.pushHeld}));
endmodule

// File: rtl/uart_flow_engine.sv
module uart_flow_engine
  import flowctl_pkg::*;
#(
  parameter int LEVEL_W = 5,
  parameter int CHAR_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               autoRtsEn,
  input  logic               autoCtsEn,
  input  logic               swFlowEn,
  input  logic               swWide,
  input  logic               mcrRts,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [LEVEL_W-1:0] haltLevel,
  input  logic [LEVEL_W-1:0] resumeLevel,
  input  logic [CHAR_W-1:0]  rxChar,
  input  logic               rxValid,
  input  logic [CHAR_W-1:0]  xon1,
  input  logic [CHAR_W-1:0]  xon2,
  input  logic [CHAR_W-1:0]  xoff1,
  input  logic [CHAR_W-1:0]  xoff2,
  input  logic               ctsN,
  input  logic               txIdle,
  input  logic               txCharDone,
  output logic               rtsN,
  output logic               txHalt,
  output logic               rxPush,
  output logic [CHAR_W-1:0]  rxPushData,
  output logic               xoffReq,
  output logic               xonReq,
  output logic               rtsIrq,
  output logic               ctsIrq,
  output logic               xoffIrq,
  output logic               xonIrq
);
  flowStrobe_t          strobes;
  logic [NUM_CODES-1:0] codeHit;

  flowctl_match_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .swFlowEn(swFlowEn), .swWide(swWide),
    .rxValid(rxValid), .hit(codeHit), .st(strobes)
  );

  flowctl_datapath #(.LEVEL_W(LEVEL_W), .CHAR_W(CHAR_W)) i_dp (
    .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
    .swFlowEn(swFlowEn), .mcrRts(mcrRts), .rxLevel(rxLevel),
    .haltLevel(haltLevel), .resumeLevel(resumeLevel), .rxChar(rxChar),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2), .ctsN(ctsN),
    .txIdle(txIdle), .txCharDone(txCharDone), .st(strobes), .hit(codeHit),
    .rtsN(rtsN), .txHalt(txHalt), .rxPush(rxPush), .rxPushData(rxPushData),
    .xoffReq(xoffReq), .xonReq(xonReq), .rtsIrq(rtsIrq), .ctsIrq(ctsIrq),
    .xoffIrq(xoffIrq), .xonIrq(xonIrq)
  );
endmodule

// File: tb/test_uart_flow_engine.sv
module test_uart_flow_engine;
  localparam int LW = 5;
  localparam int CW = 8;
  localparam logic [CW-1:0] XON1 = 8'h11, XON2 = 8'h12, XOFF1 = 8'h13, XOFF2 = 8'h14;

  logic clk = 1'b0, rstN = 1'b0;
  logic autoRtsEn = 0, autoCtsEn = 0, swFlowEn = 0, swWide = 0, mcrRts = 1;
  logic [LW-1:0] rxLevel = 0, haltLevel = 5'd12, resumeLevel = 5'd4;
  logic [CW-1:0] rxChar = 0;
  logic rxValid = 0, ctsN = 0, txIdle = 1, txCharDone = 0;
  logic rtsN, txHalt, rxPush, xoffReq, xonReq, rtsIrq, ctsIrq, xoffIrq, xonIrq;
  logic [CW-1:0] rxPushData;
  int checks = 0, errors = 0;
  logic gotPush;
  logic [CW-1:0] gotData;

  always #5 clk = ~clk;

  uart_flow_engine #(.LEVEL_W(LW), .CHAR_W(CW)) i_uart_flow_engine (
    .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
    .swFlowEn(swFlowEn), .swWide(swWide), .mcrRts(mcrRts), .rxLevel(rxLevel),
    .haltLevel(haltLevel), .resumeLevel(resumeLevel), .rxChar(rxChar),
    .rxValid(rxValid), .xon1(XON1), .xon2(XON2), .xoff1(XOFF1), .xoff2(XOFF2),
    .ctsN(ctsN), .txIdle(txIdle), .txCharDone(txCharDone), .rtsN(rtsN),
    .txHalt(txHalt), .rxPush(rxPush), .rxPushData(rxPushData),
    .xoffReq(xoffReq), .xonReq(xonReq), .rtsIrq(rtsIrq), .ctsIrq(ctsIrq),
    .xoffIrq(xoffIrq), .xonIrq(xonIrq)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // presents one character for one cycle, captures the push seen with it
  task automatic sendChar(logic [CW-1:0] c);
    rxChar = c; rxValid = 1'b1;
    #1 gotPush = rxPush; gotData = rxPushData;
    @(posedge clk); @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 txHalt", txHalt, 0);
    check("R1 rtsN", rtsN, 0);
    check("R1 pulses", {rtsIrq, ctsIrq, xoffIrq, xonIrq, xoffReq, xonReq}, 0);
    check("R1 rxPush", rxPush, 0);
  endtask

  task automatic t_disabled;
    ctsN = 1'b1;
    sendChar(XOFF1);
    check("R10 pass when sw off push", gotPush, 1);
    check("R10 pass when sw off data", gotData, XOFF1);
    step(3);
    check("R12 no halt when disabled", txHalt, 0);
    check("R6 no ctsIrq when disabled", ctsIrq, 0);
    mcrRts = 1'b0; #1;
    check("R12 rtsN follows mcr", rtsN, 1);
    mcrRts = 1'b1; ctsN = 1'b0;
    step(1);
  endtask

  task automatic t_auto_rts;
    autoRtsEn = 1; swFlowEn = 1;
    rxLevel = 5'd12; step(1);
    check("R2 equal level keeps rts", rtsN, 0);
    rxLevel = 5'd13; step(1);
    check("R2 above high raises rts", rtsN, 1);
    check("R4 rtsIrq", rtsIrq, 1);
    check("R11 xoffReq", xoffReq, 1);
    step(1);
    check("R4 rtsIrq one cycle", rtsIrq, 0);
    check("R11 xoffReq one cycle", xoffReq, 0);
    rxLevel = 5'd4; step(2);
    check("R3 hysteresis hold", rtsN, 1);
    rxLevel = 5'd3; step(1);
    check("R3 below low releases", rtsN, 0);
    check("R11 xonReq", xonReq, 1);
    swFlowEn = 0; autoRtsEn = 0; rxLevel = 0;
    step(1);
  endtask

  task automatic t_cts;
    autoCtsEn = 1; txIdle = 0;
    ctsN = 1; step(1);
    check("R6 ctsIrq", ctsIrq, 1);
    check("R5 no halt mid char", txHalt, 0);
    step(2);
    check("R6 ctsIrq one cycle", ctsIrq, 0);
    check("R5 still mid char", txHalt, 0);
    txCharDone = 1; step(1); txCharDone = 0;
    check("R5 halt at char end", txHalt, 1);
    ctsN = 0; step(2);
    check("R5 hold until boundary", txHalt, 1);
    txIdle = 1; step(1);
    check("R5 resume at boundary", txHalt, 0);
    autoCtsEn = 0; step(1);
    ctsN = 1; step(1);
    check("R6 no irq with auto off", ctsIrq, 0);
    ctsN = 0; step(1);
  endtask

  task automatic t_sw_narrow;
    swFlowEn = 1; swWide = 0;
    sendChar(8'h41);
    check("R10 data push", gotPush, 1);
    check("R10 data value", gotData, 8'h41);
    sendChar(XOFF1);
    check("R7 xoff not pushed", gotPush, 0);
    check("R7 xoffIrq", xoffIrq, 1);
    check("R7 halt waits a cycle", txHalt, 0);
    step(1);
    check("R7 halt after xoff", txHalt, 1);
    sendChar(XON1);
    check("R7 xon not pushed", gotPush, 0);
    check("R7 xonIrq", xonIrq, 1);
    step(1);
    check("R7 resume after xon", txHalt, 0);
  endtask

  task automatic t_sw_wide;
    swWide = 1;
    sendChar(XOFF1);
    check("R8 first stop byte held", gotPush, 0);
    sendChar(XOFF2);
    check("R8 second stop byte dropped", gotPush, 0);
    step(1);
    check("R8 pair halts", txHalt, 1);
    sendChar(XON1);
    check("R8 first resume byte held", gotPush, 0);
    sendChar(XON2);
    check("R8 second resume byte dropped", gotPush, 0);
    step(1);
    check("R8 pair resumes", txHalt, 0);
    sendChar(XOFF1);
    sendChar(8'h55);
    check("R9 held byte released", gotPush, 1);
    check("R9 held byte value", gotData, XOFF1);
    check("R9 new byte next cycle", rxPush, 1);
    check("R9 new byte value", rxPushData, 8'h55);
    step(1);
    check("R9 push done", rxPush, 0);
    check("R9 no stop", txHalt, 0);
  endtask

  initial begin
    fork
      begin
        step(3);
        rstN = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_auto_rts();
        t_cts();
        t_sw_narrow();
        t_sw_wide();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule